// File: doc/BRIEF.md
# Memory-mapped serial flash read engine

This block lets a bus master read a serial NOR flash as if it were plain memory. Software first stores, for each chip select, the flash read opcode, the address length, the number of dummy bytes and how many data lines the flash uses. It then sets the enable bit. From then on, each read request on the window port is turned into a complete flash read transaction. The request carries a byte offset into a 64 MiB window and a chip select. The transaction sends the opcode, the address bytes and the dummy bytes, then shifts in one data word. The word goes back to the requester on a one-cycle response.

The opcode, address and dummy phases always use a single output line. Only the data phase can widen to two or four lines. While the enable bit is clear, window reads do not reach the pins and are answered with an error.

Top module: `xip_flash_reader`

## Requirements
- R1: After reset all chip selects are high, the serial clock is low, no line is driven, no response is pending, the request grant is high and every register reads as zero.
- R2: The enable bit is bit 0 at register offset 0x64. The setup word for chip select n sits at offset 0x54+4n. Its fields are opcode [7:0], address bytes minus one [9:8], dummy byte count [11:10] and data lane code [13:12]. Reads return the stored value, and bits that do not exist read as zero.
- R3: A window read accepted while the enable bit is 0 returns on the next cycle with the error flag set and data zero. It asserts no chip select.
- R4: With the enable bit at 1, a window read takes the selected chip select low and sends, MSB first on line 0 only, the opcode, then the low (address bytes) bytes of the offset, then the dummy bytes. The serial clock runs at half the system clock in mode 0: it idles low and is never high for two cycles in a row. The number of rising edges equals the command bits plus the data steps.
- R5: Lane code 0 receives data on line 1, one bit per clock, MSB of each byte first.
- R6: Lane code 1 receives two bits per clock: line 1 carries the higher bit and line 0 the lower.
- R7: Lane code 3 receives a nibble per clock on lines 3..0, with line 3 carrying nibble bit 3 and the high nibble of each byte first.
- R8: The unused lane code 2 behaves exactly like lane code 0.
- R9: A successful read returns the four bytes starting at the flash address, with the lowest-address byte in bits [7:0], and the error flag clear.
- R10: At most one chip select is low at any time. No line is driven while all selects are high, and no line is driven during the data phase. After a transaction all selects stay high for at least two system clock cycles before the next one starts.
- R11: The setup word is captured when a request is accepted. A setup write during a transaction does not change that transaction, but it does apply to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| rd_req_i | input | 1 | Window read request |
| rd_cs_i | input | 2 | Chip select for the request |
| rd_addr_i | input | 26 | Byte offset into the window |
| rd_gnt_o | output | 1 | Request accepted in this cycle when high |
| rd_valid_o | output | 1 | Response valid, one cycle |
| rd_err_o | output | 1 | Response is an error |
| rd_data_o | output | 32 | Response data word |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 4 | Chip selects, active low |
| io_o | output | 4 | Serial data out |
| io_oe_o | output | 4 | Serial data output enables |
| io_i | input | 4 | Serial data in |

## Verification
The bench models the flash at the pins. It decodes the opcode and address, checks the edge count, and serves data in the lane mode it recorded when the select fell. This lets it catch several kinds of fault:
- Byte or nibble order swapped within a lane mode, which shows up as scrambled words.
- A 3-byte address sent as four bytes, or not truncated above 16 MiB, which shows up as wrong addresses and edge counts.
- Lane code 2 decoded as dual.
- A missing gap between back-to-back reads.
- Reads issued while disabled that still toggle the pins.
- A setup write in mid-transaction that leaks into the running transaction, which would change the opcode or the cycle count seen by the model.

// File: rtl/xip_pkg.sv
package xip_pkg;
  localparam int REG_AW = 8;
  localparam logic [REG_AW-1:0] OFS_SWITCH = 8'h64;
  localparam logic [REG_AW-1:0] OFS_SETUP0 = 8'h54;

  typedef enum logic [1:0] {
    LANE_X1  = 2'd0,
    LANE_X2  = 2'd1,
    LANE_RSV = 2'd2,
    LANE_X4  = 2'd3
  } lane_e;

  // Field order matches the setup word bit layout [13:0]
  typedef struct packed {
    lane_e      lane;
    logic [1:0] dummy;
    logic [1:0] alen;
    logic [7:0] opcode;
  } setup_t;

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_DATA, ST_GAP} state_e;

  function automatic int lane_width(lane_e l);
    case (l)
      LANE_X4: return 4;
      LANE_X2: return 2;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/xip_regs.sv
module xip_regs import xip_pkg::*; #(
  parameter int NUM_CS = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [REG_AW-1:0]         addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output logic                      mode_o,
  output setup_t [NUM_CS-1:0]       setup_o
);
  localparam int SETUP_W = $bits(setup_t);

  logic   mode_q;
  setup_t [NUM_CS-1:0] setup_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           mode_q <= 1'b0;
    else if (we_i && addr_i == OFS_SWITCH) mode_q <= wdata_i[0];
  end

  for (genvar n = 0; n < NUM_CS; n++) begin : g_setup
    localparam logic [REG_AW-1:0] OFS = REG_AW'(int'(OFS_SETUP0) + 4 * n);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    setup_q[n] <= '0;
      else if (we_i && addr_i == OFS) setup_q[n] <= setup_t'(wdata_i[SETUP_W-1:0]);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_SWITCH) rdata_o[0] = mode_q;
    for (int n = 0; n < NUM_CS; n++) begin
      if (addr_i == REG_AW'(int'(OFS_SETUP0) + 4 * n)) rdata_o[SETUP_W-1:0] = setup_q[n];
    end
  end

  assign mode_o  = mode_q;
  assign setup_o = setup_q;
endmodule

// File: rtl/xip_rx.sv
module xip_rx import xip_pkg::*; #(
  parameter  int WORD_BYTES = 4,
  localparam int WORD_BITS  = 8 * WORD_BYTES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  lane_e                lane_i,
  input  logic [3:0]           io_i,
  output logic [WORD_BITS-1:0] word_o
);
  logic [WORD_BITS-1:0] sr_q, sr_nxt;

  always_comb begin
    case (lane_i)
      LANE_X4: sr_nxt = {sr_q[WORD_BITS-5:0], io_i};
      LANE_X2: sr_nxt = {sr_q[WORD_BITS-3:0], io_i[1:0]};
      default: sr_nxt = {sr_q[WORD_BITS-2:0], io_i[1]};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= sr_nxt;
  end

  // First received byte lands in the low byte of the word
  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_swap
    assign word_o[8*b +: 8] = sr_nxt[WORD_BITS-8-8*b +: 8];
  end
endmodule

// File: rtl/xip_seq.sv
module xip_seq import xip_pkg::*; #(
  parameter  int NUM_CS     = 4,
  parameter  int WIN_AW     = 26,
  parameter  int WORD_BYTES = 4,
  parameter  int GAP_CYC    = 2,
  localparam int CSW        = $clog2(NUM_CS),
  localparam int WORD_BITS  = 8 * WORD_BYTES,
  localparam int TX_BITS    = 8 + 32 + 24,
  localparam int CNT_W      = $clog2(TX_BITS + WORD_BITS) + 1,
  localparam int GAP_W      = $clog2(GAP_CYC + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_i,
  input  setup_t [NUM_CS-1:0]  setup_i,
  input  logic                 req_i,
  input  logic [CSW-1:0]       cs_i,
  input  logic [WIN_AW-1:0]    addr_i,
  output logic                 gnt_o,
  output logic                 rsp_valid_o,
  output logic                 rsp_err_o,
  output logic [WORD_BITS-1:0] rsp_data_o,
  output lane_e                lane_o,
  output logic                 rx_shift_o,
  input  logic [WORD_BITS-1:0] rx_word_i,
  output logic                 sclk_o,
  output logic [NUM_CS-1:0]    cs_no,
  output logic [3:0]           io_o,
  output logic [3:0]           io_oe_o
);
  state_e               st_q;
  setup_t               cfg_q;
  logic [CSW-1:0]       cs_q;
  logic [TX_BITS-1:0]   tx_q, tx_load;
  logic [CNT_W-1:0]     cnt_q, cmd_last, data_last;
  logic [GAP_W-1:0]     gap_q;
  logic                 ph_q, sclk_q;
  logic                 vld_q, err_q;
  logic [WORD_BITS-1:0] data_q;
  setup_t               sel;
  logic [31:0]          addr32;

  assign sel    = setup_i[cs_i];
  assign addr32 = 32'(addr_i);

  // Address left-aligned in a 32-bit slot, dummy slot zero
  always_comb begin
    tx_load = {sel.opcode, addr32 << (6'd8 * (6'd3 - 6'(sel.alen))), 24'h0};
  end

  assign cmd_last  = CNT_W'(8 * int'(cfg_q.alen) + 8 * int'(cfg_q.dummy) + 15);
  assign data_last = CNT_W'(WORD_BITS / lane_width(cfg_q.lane) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      cs_q   <= '0;
      tx_q   <= '0;
      cnt_q  <= '0;
      gap_q  <= '0;
      ph_q   <= 1'b0;
      sclk_q <= 1'b0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_i) begin
            if (!mode_i) begin
              vld_q  <= 1'b1;
              err_q  <= 1'b1;
              data_q <= '0;
            end else begin
              cfg_q <= sel;
              cs_q  <= cs_i;
              tx_q  <= tx_load;
              cnt_q <= '0;
              ph_q  <= 1'b0;
              st_q  <= ST_CMD;
            end
          end
        end
        ST_CMD: begin
          ph_q   <= ~ph_q;
          sclk_q <= ~ph_q;
          if (ph_q) begin
            tx_q  <= tx_q << 1;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == cmd_last) begin
              cnt_q <= '0;
              st_q  <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          ph_q   <= ~ph_q;
          sclk_q <= ~ph_q;
          if (ph_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == data_last) begin
              st_q   <= ST_GAP;
              gap_q  <= '0;
              vld_q  <= 1'b1;
              err_q  <= 1'b0;
              data_q <= rx_word_i;
            end
          end
        end
        default: begin
          gap_q <= gap_q + 1'b1;
          if (gap_q == GAP_W'(GAP_CYC - 1)) st_q <= ST_IDLE;
        end
      endcase
    end
  end

  logic busy;
  assign busy        = (st_q == ST_CMD) || (st_q == ST_DATA);
  assign gnt_o       = (st_q == ST_IDLE);
  assign rsp_valid_o = vld_q;
  assign rsp_err_o   = err_q;
  assign rsp_data_o  = data_q;
  assign lane_o      = cfg_q.lane;
  assign rx_shift_o  = (st_q == ST_DATA) && ph_q;
  assign sclk_o      = sclk_q;
  assign cs_no       = busy ? ~(NUM_CS'(1) << cs_q) : '1;
  assign io_o        = {3'b000, (st_q == ST_CMD) & tx_q[TX_BITS-1]};
  assign io_oe_o     = {3'b000, st_q == ST_CMD};
endmodule

// File: rtl/xip_flash_reader.sv
module xip_flash_reader import xip_pkg::*; #(
  parameter  int NUM_CS     = 4,
  parameter  int WIN_AW     = 26,
  parameter  int WORD_BYTES = 4,
  parameter  int GAP_CYC    = 2,
  localparam int CSW        = $clog2(NUM_CS),
  localparam int WORD_BITS  = 8 * WORD_BYTES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [REG_AW-1:0]    reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  input  logic                 rd_req_i,
  input  logic [CSW-1:0]       rd_cs_i,
  input  logic [WIN_AW-1:0]    rd_addr_i,
  output logic                 rd_gnt_o,
  output logic                 rd_valid_o,
  output logic                 rd_err_o,
  output logic [WORD_BITS-1:0] rd_data_o,
  output logic                 sclk_o,
  output logic [NUM_CS-1:0]    cs_no,
  output logic [3:0]           io_o,
  output logic [3:0]           io_oe_o,
  input  logic [3:0]           io_i
);
  logic                 mode;
  setup_t [NUM_CS-1:0]  setup;
  lane_e                lane;
  logic                 rx_shift;
  logic [WORD_BITS-1:0] rx_word;

  xip_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .mode_o(mode), .setup_o(setup)
  );

  xip_seq #(.NUM_CS(NUM_CS), .WIN_AW(WIN_AW), .WORD_BYTES(WORD_BYTES), .GAP_CYC(GAP_CYC)) u_seq (
    .clk_i, .rst_ni,
    .mode_i(mode), .setup_i(setup),
    .req_i(rd_req_i), .cs_i(rd_cs_i), .addr_i(rd_addr_i), .gnt_o(rd_gnt_o),
    .rsp_valid_o(rd_valid_o), .rsp_err_o(rd_err_o), .rsp_data_o(rd_data_o),
    .lane_o(lane), .rx_shift_o(rx_shift), .rx_word_i(rx_word),
    .sclk_o, .cs_no, .io_o, .io_oe_o
  );

  xip_rx #(.WORD_BYTES(WORD_BYTES)) u_rx (
    .clk_i, .rst_ni,
    .shift_i(rx_shift), .lane_i(lane), .io_i, .word_o(rx_word)
  );
endmodule

// File: rtl/xip_flash_reader_chk.sv
module xip_flash_reader_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_i,
  input logic              rd_req_i,
  input logic              rd_gnt_i,
  input logic              rd_valid_i,
  input logic              rd_err_i,
  input logic              sclk_i,
  input logic [NUM_CS-1:0] cs_ni,
  input logic [3:0]        io_oe_i
);
  p_cs_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_ni));
  p_oe_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &cs_ni |-> io_oe_i == 4'b0000);
  p_cs_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(&cs_ni) |=> &cs_ni);
  p_sclk_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &cs_ni |-> !sclk_i);
  p_sclk_half_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_i |=> !sclk_i);
  p_off_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i && rd_gnt_i && !mode_i |=> rd_valid_i && rd_err_i && &cs_ni);
  p_busy_no_gnt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&cs_ni) |-> !rd_gnt_i);
endmodule

bind xip_flash_reader xip_flash_reader_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk_i, .rst_ni, .mode_i(mode), .rd_req_i, .rd_gnt_i(rd_gnt_o),
  .rd_valid_i(rd_valid_o), .rd_err_i(rd_err_o), .sclk_i(sclk_o),
  .cs_ni(cs_no), .io_oe_i(io_oe_o)
);

// File: tb/tb_xip_flash_reader.sv
`timescale 1ns/1ps
module tb_xip_flash_reader;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = 8'h0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        rd_req_i = 1'b0;
  logic [1:0]  rd_cs_i = '0;
  logic [25:0] rd_addr_i = '0;
  logic        rd_gnt_o, rd_valid_o, rd_err_o;
  logic [31:0] rd_data_o;
  logic        sclk_o;
  logic [3:0]  cs_no, io_o, io_oe_o;
  logic [3:0]  io_i = 4'h0;

  always #2.5 clk_i = ~clk_i;

  xip_flash_reader dut (.*);

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench copy of the programmed configuration
  logic [7:0] b_op [4];
  logic [1:0] b_aw [4], b_dm [4], b_ln [4];
  logic       b_mode = 1'b0;
  initial for (int i = 0; i < 4; i++) begin b_op[i] = 0; b_aw[i] = 0; b_dm[i] = 0; b_ln[i] = 0; end

  function automatic int lanes(input logic [1:0] c);
    return (c == 2'd3) ? 4 : (c == 2'd1) ? 2 : 1;
  endfunction

  function automatic logic [7:0] mem_byte(input int cs, input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ {4{2'(cs)}} ^ 8'hA5;
  endfunction

  // Scoreboard queues
  logic [32:0] sb_q[$];
  string       sb_tag[$];
  logic [31:0] fa_q[$];

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    if (a == 8'h64) b_mode = d[0];
    for (int n = 0; n < 4; n++)
      if (a == 8'(8'h54 + 4 * n)) begin
        b_op[n] = d[7:0]; b_aw[n] = d[9:8]; b_dm[n] = d[11:10]; b_ln[n] = d[13:12];
      end
  endtask

  task automatic reg_check(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk_i);
    reg_addr_i = a;
    #1;
    chk(reg_rdata_o == exp, req, 64'(reg_rdata_o), 64'(exp));
  endtask

  task automatic do_read(input int cs, input logic [25:0] a, input string tag);
    logic [31:0] eff, w;
    eff = 32'(a);
    if (b_aw[cs] != 2'd3) eff = eff & ((32'd1 << (8 * (int'(b_aw[cs]) + 1))) - 1);
    for (int j = 0; j < 4; j++) w[8*j +: 8] = mem_byte(cs, eff + 32'(j));
    if (b_mode) begin sb_q.push_back({1'b0, w}); fa_q.push_back(eff); end
    else        sb_q.push_back({1'b1, 32'h0});
    sb_tag.push_back(tag);
    do @(negedge clk_i); while (!rd_gnt_o);
    rd_req_i = 1'b1; rd_cs_i = 2'(cs); rd_addr_i = a;
    @(negedge clk_i);
    rd_req_i = 1'b0;
  endtask

  task automatic wait_done();
    while (sb_q.size() != 0 || !rd_gnt_o) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
  endtask

  // Monitor
  always @(negedge clk_i) if (rst_ni && rd_valid_o) begin
    if (sb_q.size() == 0) chk(1'b0, "R9 unexpected response", 64'(rd_data_o), 64'h0);
    else begin
      logic [32:0] e;
      string t;
      e = sb_q.pop_front();
      t = sb_tag.pop_front();
      chk({rd_err_o, rd_data_o} == e, t, 64'({rd_err_o, rd_data_o}), 64'(e));
    end
  end

  // Flash model
  int          hi_cnt = 0;
  always @(posedge clk_i) if (&cs_no) hi_cnt++; else hi_cnt = 0;

  bit          fm_on = 0, fm_oe_bad = 0;
  int          fm_cnt, fm_cmd, fm_na, fm_cs, fm_l, fm_txn = 0;
  logic [7:0]  fm_op, fm_exp_op;
  logic [31:0] fm_addr;

  always @(cs_no) begin
    if (!(&cs_no) && !fm_on) begin
      fm_on = 1; fm_cnt = 0; fm_addr = 0; fm_op = 0; fm_oe_bad = 0; fm_txn++;
      fm_cs = 0;
      for (int n = 0; n < 4; n++) if (!cs_no[n]) fm_cs = n;
      fm_na = int'(b_aw[fm_cs]) + 1;
      fm_cmd = 8 + 8 * fm_na + 8 * int'(b_dm[fm_cs]);
      fm_l = lanes(b_ln[fm_cs]);
      fm_exp_op = b_op[fm_cs];
      chk(hi_cnt >= 2, "R10 select gap", 64'(hi_cnt), 64'd2);
    end else if (&cs_no && fm_on) begin
      logic [31:0] ea;
      fm_on = 0; io_i = 4'h0;
      ea = (fa_q.size() != 0) ? fa_q.pop_front() : 32'hFFFF_FFFF;
      chk(fm_op == fm_exp_op, "R4/R11 opcode", 64'(fm_op), 64'(fm_exp_op));
      chk(fm_addr == ea, "R4 address", 64'(fm_addr), 64'(ea));
      chk(fm_cnt == fm_cmd + 32 / fm_l, "R4 edge count", 64'(fm_cnt), 64'(fm_cmd + 32 / fm_l));
      chk(!fm_oe_bad, "R10 data phase undriven", 64'(fm_oe_bad), 64'd0);
    end
  end

  always @(posedge sclk_o) if (fm_on) begin
    if (fm_cnt < fm_cmd && io_oe_o != 4'b0001) fm_oe_bad = 1;
    if (fm_cnt >= fm_cmd && io_oe_o != 4'b0000) fm_oe_bad = 1;
    if (fm_cnt < 8) fm_op = {fm_op[6:0], io_o[0]};
    else if (fm_cnt < 8 + 8 * fm_na) fm_addr = {fm_addr[30:0], io_o[0]};
    fm_cnt++;
  end

  always @(negedge sclk_o) if (fm_on && fm_cnt >= fm_cmd) begin
    int bit0, pos;
    logic [7:0] by, sh;
    bit0 = (fm_cnt - fm_cmd) * fm_l;
    pos = bit0 % 8;
    by = mem_byte(fm_cs, fm_addr + 32'(bit0 / 8));
    sh = by >> (8 - pos - fm_l);
    case (fm_l)
      4:       io_i = sh[3:0];
      2:       io_i = {2'b00, sh[1:0]};
      default: io_i = {2'b00, sh[0], 1'b0};
    endcase
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(cs_no == 4'hF, "R1 selects high", 64'(cs_no), 64'hF);
    chk(!sclk_o && io_oe_o == 0, "R1 clock low, lines undriven", 64'({sclk_o, io_oe_o}), 64'h0);
    chk(!rd_valid_o && rd_gnt_o, "R1 no response, grant high", 64'({rd_valid_o, rd_gnt_o}), 64'h1);
    rst_ni = 1'b1;
    reg_check(8'h64, 32'h0, "R1 switch reads zero");
    reg_check(8'h58, 32'h0, "R1 setup1 reads zero");

    // R2 register map and readback
    reg_write(8'h60, 32'hFFFF_FFFF);
    reg_check(8'h60, 32'h0000_3FFF, "R2 setup3 unused bits zero");
    reg_write(8'h64, 32'hFFFF_FFFE);
    reg_check(8'h64, 32'h0, "R2 switch bit0 only");

    // R3 read while disabled
    reg_write(8'h54, 32'h0000_0203);
    t0 = fm_txn;
    do_read(0, 26'h12_3456, "R3 disabled read errors");
    wait_done();
    chk(fm_txn == t0, "R3 no bus activity", 64'(fm_txn), 64'(t0));

    reg_write(8'h64, 32'h1);
    reg_check(8'h64, 32'h1, "R2 switch enabled");
    reg_check(8'h54, 32'h0000_0203, "R2 setup0 readback");

    // R4 R5 R9: single lane, 3-byte address, no dummy
    do_read(0, 26'h00_1234, "R5 single lane word");
    do_read(0, 26'h3F_FFFC, "R9 single lane word high offset");
    wait_done();

    // R6 dual lane, 4-byte address, 1 dummy
    reg_write(8'h58, 32'h0000_173B);
    do_read(1, 26'h2AB_CDEF, "R6 dual lane word");
    wait_done();

    // R7 quad lane, 3-byte address truncates offset above 16 MiB
    reg_write(8'h5C, 32'h0000_366B);
    do_read(2, 26'h3A5_5A00, "R7 quad lane word, truncated address");
    do_read(2, 26'h000_0001, "R7 quad lane word back-to-back");
    wait_done();

    // R8 reserved lane code acts as single; 1-byte address, 3 dummy
    reg_write(8'h60, 32'h0000_2C0B);
    do_read(3, 26'h000_0077, "R8 reserved lane code as single");
    wait_done();

    // R10 back-to-back on different selects
    do_read(1, 26'h000_0010, "R10 back-to-back first");
    do_read(0, 26'h000_0020, "R10 back-to-back second");
    wait_done();

    // R11 setup write mid-transaction does not affect it
    do_read(0, 26'h000_0100, "R11 snapshot word");
    wait (fm_on);
    repeat (6) @(negedge clk_i);
    reg_write(8'h54, 32'h0000_3DEB);
    wait_done();
    do_read(0, 26'h000_0200, "R11 new setup applies next");
    wait_done();

    // R3 again after disabling
    reg_write(8'h64, 32'h0);
    t0 = fm_txn;
    do_read(2, 26'h000_0300, "R3 disabled again errors");
    wait_done();
    chk(fm_txn == t0, "R3 no bus activity after disable", 64'(fm_txn), 64'(t0));
    chk(cs_no == 4'hF && !sclk_o, "R1 idle pins after run", 64'({cs_no, sclk_o}), 64'h1E);

    finish_run();
  end
endmodule